// File: doc/BRIEF.md
# Multi-Source Interrupt Status Aggregator

This block gathers three interrupt causes into one level-sensitive interrupt request so that a single service routine can handle all of them. The causes are a push into a full FIFO (an overflow), a descriptor that has finished while its interrupt flag is set, and an external interrupt input. Each cause has its own bit in a control/status word, and this bit is set on the rising edge of the cause.

Software reads the control/status word to find out which causes are pending. It then writes the word back to clear them. A bit written as zero is cleared, and a bit written as one is left unchanged, so writing all zeros clears everything. The same write also loads three enable bits, one per cause. The request output is a registered OR of every pending cause whose enable bit is set.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, all status bits, all enable bits and `irq_req_o` are 0, and `csr_rdata_o` reads 0.
- R2: Status bit 0 (overflow) is set when `fifo_push_i` and `fifo_full_i` are both high in a cycle and were not both high in the cycle before. A push while the FIFO is not full does not set it.
- R3: Status bit 1 (descriptor) is set on the rising edge of `desc_done_i` AND `desc_irq_flag_i`. A completion whose flag is low does not set it.
- R4: Status bit 2 (external) is set on a rising edge of `ext_irq_i`. A level held high sets the bit only once, so after software clears it the bit stays clear until the input goes low and rises again.
- R5: A status bit stays set while no write clears it, even after its cause has gone low.
- R6: A write with `csr_wr_i` high clears every status bit whose `csr_wdata_i` bit (bits 2:0) is 0. It leaves unchanged every status bit whose data bit is 1, and it never sets a status bit. The same write loads enable bits 10:8 from `csr_wdata_i[10:8]`.
- R7: If a cause's rising edge happens in the same cycle as a write that clears its bit, the bit ends the cycle set.
- R8: `irq_req_o` is high one cycle after any status bit is set together with its enable bit, and low one cycle after no such pair remains.
- R9: `csr_rdata_o` shows the status bits in [2:0] (overflow, descriptor, external) and the enable bits in [10:8] in the same order. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_push_i | input | 1 | Push attempt into the stream FIFO |
| fifo_full_i | input | 1 | Stream FIFO is full |
| desc_done_i | input | 1 | A descriptor has finished processing |
| desc_irq_flag_i | input | 1 | Interrupt-on-completion flag of that descriptor |
| ext_irq_i | input | 1 | External interrupt input |
| csr_wr_i | input | 1 | Write strobe for the control/status word |
| csr_wdata_i | input | 32 | Write data for the control/status word |
| csr_rdata_o | output | 32 | Current control/status word |
| irq_req_o | output | 1 | Combined interrupt request |

## Verification
A wrong edge-detector history shows up at `csr_rdata_o` in the same cycle after the clock edge. Two examples: a held external level that sets its bit again after it was cleared, or an overflow that is missed after reset. A status or enable register that drops a bit, or fails to clear one, appears in the readback one cycle after the write or event that should have changed it. A fault in the request stage appears on `irq_req_o` one cycle after the status/enable pair changes. The bench therefore compares the full readback word and the request on every cycle, against a model that it steps beside the design.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC  = 3;
    localparam int CSR_W    = 32;
    localparam int STAT_LSB = 0;
    localparam int MASK_LSB = 8;

    localparam int SRC_OVF  = 0;
    localparam int SRC_DESC = 1;
    localparam int SRC_EXT  = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t pending;
        src_vec_t enable;
    } csr_state_t;

    typedef struct packed {
        logic             wr;
        logic [CSR_W-1:0] data;
    } csr_wr_t;

    function automatic logic [CSR_W-1:0] csr_pack(csr_state_t s);
        logic [CSR_W-1:0] w;
        w = '0;
        w[STAT_LSB +: NUM_SRC] = s.pending;
        w[MASK_LSB +: NUM_SRC] = s.enable;
        return w;
    endfunction

    function automatic src_vec_t csr_status_field(logic [CSR_W-1:0] w);
        return w[STAT_LSB +: NUM_SRC];
    endfunction

    function automatic src_vec_t csr_mask_field(logic [CSR_W-1:0] w);
        return w[MASK_LSB +: NUM_SRC];
    endfunction

endpackage

// File: rtl/irq_cause_decode.sv
module irq_cause_decode
    import irq_agg_pkg::*;
(
    input  logic     fifo_push_i,
    input  logic     fifo_full_i,
    input  logic     desc_done_i,
    input  logic     desc_irq_flag_i,
    input  logic     ext_irq_i,
    output src_vec_t cause_o
);

    always_comb begin
        cause_o           = '0;
        cause_o[SRC_OVF]  = fifo_push_i & fifo_full_i;
        cause_o[SRC_DESC] = desc_done_i & desc_irq_flag_i;
        cause_o[SRC_EXT]  = ext_irq_i;
    end

endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic hist_q;

        always_ff @(posedge clk) begin
            if (rst) hist_q <= 1'b0;
            else     hist_q <= level_i[g];
        end

        assign rise_o[g] = level_i[g] & ~hist_q;

        // R4
        rise_once_chk: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/irq_status_csr.sv
module irq_status_csr
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  src_vec_t         event_i,
    input  csr_wr_t          wr_i,
    output csr_state_t       state_o,
    output logic [CSR_W-1:0] rdata_o
);

    csr_state_t state_q;
    csr_state_t state_d;
    src_vec_t   keep_mask;
    logic       wdata_unused;

    assign wdata_unused = ^wr_i.data;

    always_comb begin
        keep_mask = wr_i.wr ? csr_status_field(wr_i.data) : '1;
        state_d.pending = (state_q.pending & keep_mask) | event_i;
        state_d.enable  = wr_i.wr ? csr_mask_field(wr_i.data) : state_q.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
    assign rdata_o = csr_pack(state_q);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R5
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (state_q.pending[g] && !wr_i.wr) |=> state_q.pending[g]);
        // R7
        event_wins_chk: assert property (@(posedge clk) disable iff (rst)
            event_i[g] |=> state_q.pending[g]);
        // R6
        write_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_i.wr && !wr_i.data[STAT_LSB + g] && !event_i[g]) |=> !state_q.pending[g]);
        // R6
        no_write_set_chk: assert property (@(posedge clk) disable iff (rst)
            (!state_q.pending[g] && !event_i[g]) |=> !state_q.pending[g]);
    end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  csr_state_t state_i,
    output logic       irq_o
);

    logic any_armed;

    assign any_armed = |(state_i.pending & state_i.enable);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= any_armed;
    end

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state_i.pending == '0) |=> !irq_o);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_push_i,
    input  logic             fifo_full_i,
    input  logic             desc_done_i,
    input  logic             desc_irq_flag_i,
    input  logic             ext_irq_i,
    input  logic             csr_wr_i,
    input  logic [CSR_W-1:0] csr_wdata_i,
    output logic [CSR_W-1:0] csr_rdata_o,
    output logic             irq_req_o
);

    src_vec_t   cause;
    src_vec_t   rise;
    csr_wr_t    wr;
    csr_state_t state;

    assign wr.wr   = csr_wr_i;
    assign wr.data = csr_wdata_i;

    irq_cause_decode u_decode (
        .fifo_push_i     (fifo_push_i),
        .fifo_full_i     (fifo_full_i),
        .desc_done_i     (desc_done_i),
        .desc_irq_flag_i (desc_irq_flag_i),
        .ext_irq_i       (ext_irq_i),
        .cause_o         (cause)
    );

    irq_edge_capture #(.WIDTH(NUM_SRC)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (cause),
        .rise_o  (rise)
    );

    irq_status_csr u_csr (
        .clk     (clk),
        .rst     (rst),
        .event_i (rise),
        .wr_i    (wr),
        .state_o (state),
        .rdata_o (csr_rdata_o)
    );

    irq_req_gen u_req (
        .clk     (clk),
        .rst     (rst),
        .state_i (state),
        .irq_o   (irq_req_o)
    );

    // R9
    rdata_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata_o & ~32'h0000_0707) == '0);

    // R2
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_full_i && !csr_rdata_o[SRC_OVF]) |=> !csr_rdata_o[SRC_OVF]);

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        fifo_push_i, fifo_full_i, desc_done_i, desc_irq_flag_i, ext_irq_i;
    logic        csr_wr_i;
    logic [31:0] csr_wdata_i;
    logic [31:0] csr_rdata_o;
    logic        irq_req_o;

    always #5 clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst(rst),
        .fifo_push_i(fifo_push_i), .fifo_full_i(fifo_full_i),
        .desc_done_i(desc_done_i), .desc_irq_flag_i(desc_irq_flag_i),
        .ext_irq_i(ext_irq_i), .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o), .irq_req_o(irq_req_o)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // bench-side model state
    logic [2:0] m_prev, m_stat, m_mask;
    logic       m_irq;

    task automatic step(input logic r, input logic push, input logic full,
                        input logic dd, input logic df, input logic ext,
                        input logic wr, input logic [31:0] wd, input string tag);
        logic [2:0] lvl, ev, ns, nm;
        logic       ni;
        exp_t       e;
        @(negedge clk);
        rst = r; fifo_push_i = push; fifo_full_i = full;
        desc_done_i = dd; desc_irq_flag_i = df; ext_irq_i = ext;
        csr_wr_i = wr; csr_wdata_i = wd;
        lvl = {ext, dd & df, push & full};
        if (r) begin
            ns = '0; nm = '0; ni = 1'b0; m_prev = '0;
        end else begin
            ev = lvl & ~m_prev;
            ns = (wr ? (m_stat & wd[2:0]) : m_stat) | ev;
            nm = wr ? wd[10:8] : m_mask;
            ni = |(m_stat & m_mask);
            m_prev = lvl;
        end
        m_stat = ns; m_mask = nm; m_irq = ni;
        e.rdata = {21'd0, nm, 5'd0, ns};
        e.irq   = ni;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 32'h0, tag);
    endtask

    task automatic wr_csr(input logic [31:0] wd, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, wd, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (csr_rdata_o !== e.rdata || irq_req_o !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, csr_rdata_o, irq_req_o, e.rdata, e.irq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_prev = '0; m_stat = '0; m_mask = '0; m_irq = 1'b0;
        rst = 1; fifo_push_i = 0; fifo_full_i = 0; desc_done_i = 0;
        desc_irq_flag_i = 0; ext_irq_i = 0; csr_wr_i = 0; csr_wdata_i = '0;
        // R1: reset state, even with causes active
        step(1, 1, 1, 1, 1, 1, 0, 32'h0, "R1 reset");
        step(1, 0, 0, 0, 0, 0, 0, 32'h0, "R1 reset");
        idle("R1 idle after reset");
        // R2: push without full ignored, then overflow
        step(0, 1, 0, 0, 0, 0, 0, 32'h0, "R2 push not full");
        step(0, 0, 1, 0, 0, 0, 0, 32'h0, "R2 full no push");
        step(0, 1, 1, 0, 0, 0, 0, 32'h0, "R2 overflow");
        // R5: sticky after cause drops
        idle("R5 sticky");
        idle("R5 sticky");
        // R8: masked bit does not raise irq; enable it
        wr_csr(32'h0000_0101, "R6 enable ovf keep status");
        idle("R8 irq rises");
        idle("R8 irq held");
        // R6: clear by writing zero to status keeps mask
        wr_csr(32'h0000_0100, "R6 clear ovf");
        idle("R8 irq falls");
        // R3: done without flag ignored, then with flag
        step(0, 0, 0, 1, 0, 0, 0, 32'h0, "R3 done no flag");
        step(0, 0, 0, 0, 1, 0, 0, 32'h0, "R3 flag no done");
        step(0, 0, 0, 1, 1, 0, 0, 32'h0, "R3 done with flag");
        idle("R8 desc masked no irq");
        // R4: external held high sets once
        wr_csr(32'h0000_0400, "R6 enable ext clear all status");
        step(0, 0, 0, 0, 0, 1, 0, 32'h0, "R4 ext rise");
        step(0, 0, 0, 0, 0, 1, 1, 32'h0000_0400, "R4 ext clear while held");
        step(0, 0, 0, 0, 0, 1, 0, 32'h0, "R4 held no reset bit");
        step(0, 0, 0, 0, 0, 0, 0, 32'h0, "R4 ext low");
        step(0, 0, 0, 0, 0, 1, 0, 32'h0, "R4 ext rise again");
        // R7: event same cycle as clearing write wins
        step(0, 0, 0, 1, 1, 0, 1, 32'h0000_0700, "R7 desc event vs clear");
        idle("R7 after");
        // R6: write of 1 cannot set status; partial clear
        wr_csr(32'h0000_0707, "R6 ones keep");
        wr_csr(32'h0000_0702, "R6 partial clear");
        // R9: reserved bits read zero
        wr_csr(32'hFFFF_F8F8, "R9 reserved bits");
        idle("R9 readback");
        // R7 for overflow and external together
        step(0, 1, 1, 0, 0, 1, 1, 32'h0000_0700, "R7 two events vs clear");
        idle("R8 all enabled");
        wr_csr(32'h0, "R6 write zero clears all");
        idle("R1 quiet");
        // R1: reset mid-run
        step(0, 0, 0, 0, 0, 1, 0, 32'h0, "R4 ext");
        step(1, 0, 0, 0, 0, 0, 0, 32'h0, "R1 reset mid-run");
        idle("R1 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule